// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands over a fixed run of clock cycles using one shared adder. Pulsing start while the block is idle captures both operands: the multiplicand goes into a holding register, the multiplier goes into a shift register, and an accumulator is cleared. In each step the lowest bit of the shift register decides whether the multiplicand or zero is added to the accumulator. The adder's carry, the accumulator and the shift register then move right by one place together. After WIDTH steps the accumulator holds the upper half of the double-width product and the shift register holds the lower half.

A mode input, sampled together with the operands, selects sign-magnitude operation. In that mode the top bit of each operand is a sign and the remaining bits are a magnitude. The magnitudes are multiplied, and the product's top bit is set to the XOR of the two signs. busy, done and start are plain control pins with no back-pressure. A caller waits for done and then reads the product, which stays unchanged until the next start is accepted.

Top module: `shift_add_mult`

## Requirements
- R1: After reset, busy_o and done_o are 0 and product_o is all zeros.
- R2: A start_i accepted while idle makes busy_o high from the next cycle for exactly WIDTH consecutive cycles.
- R3: done_o is high for exactly one cycle, in the cycle right after the last busy cycle, and busy_o is 0 in that cycle.
- R4: With signed_i = 0 at start, product_o in the done cycle equals mcand_i × mplier_i as a full 2·WIDTH-bit unsigned value. This includes zero operands.
- R5: All-ones × all-ones gives (2^WIDTH−1)², so no carry out of the adder is lost.
- R6: With signed_i = 1 at start, bit WIDTH−1 of each operand is its sign and bits WIDTH−2..0 are its magnitude. product_o[2·WIDTH−1] is the XOR of the two signs, and product_o[2·WIDTH−2:0] is the product of the magnitudes, zero-extended.
- R7: start_i, operand and mode changes while busy_o is high have no effect on the busy timing or on the product delivered at done.
- R8: After done, product_o holds its value and busy_o and done_o stay 0 until a new start_i is accepted.
- R9: A start_i in the done cycle is accepted, so operations can run back to back every WIDTH+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a multiplication; ignored while busy |
| signed_i | input | 1 | 1 = sign-magnitude operands, 0 = unsigned |
| mcand_i | input | WIDTH | Multiplicand |
| mplier_i | input | WIDTH | Multiplier |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | One-cycle pulse: product is valid |
| product_o | output | 2·WIDTH | Double-width product |

## Verification
Every multiplicand from 0 to 255 is paired with a spread of multipliers. This spread covers all low values, all values from 248 to 255 and an even stride between them, so zero, one and all-ones each meet every partner, and runs that need carries are kept apart from runs that do not. The sign-magnitude sweep pairs every multiplicand with multipliers that include a negative zero and the largest magnitudes, which separates the sign XOR from the magnitude product. Some runs toggle start, the operands and the mode during busy to show that only the captured values count. Back-to-back starts and idle gaps separate the one-cycle done pulse from the held product.

// File: rtl/shamul_pkg.sv
`timescale 1ns/1ps
package shamul_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_t;
endpackage

// File: rtl/shamul_operand_prep.sv
`timescale 1ns/1ps
module shamul_operand_prep #(
  parameter int WIDTH = 8
) (
  input  logic             signed_i,
  input  logic [WIDTH-1:0] mcand_i,
  input  logic [WIDTH-1:0] mplier_i,
  output logic [WIDTH-1:0] mcand_mag_o,
  output logic [WIDTH-1:0] mplier_mag_o,
  output logic             neg_o
);
  localparam int MAG_W = WIDTH - 1;

  // In sign-magnitude mode the sign bit is stripped and later re-applied.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_mag
      if (i < MAG_W) begin : g_low
        assign mcand_mag_o[i]  = mcand_i[i];
        assign mplier_mag_o[i] = mplier_i[i];
      end else begin : g_top
        assign mcand_mag_o[i]  = mcand_i[i]  & ~signed_i;
        assign mplier_mag_o[i] = mplier_i[i] & ~signed_i;
      end
    end
  endgenerate

  assign neg_o = signed_i & (mcand_i[WIDTH-1] ^ mplier_i[WIDTH-1]);
endmodule

// File: rtl/shamul_ctrl.sv
`timescale 1ns/1ps
module shamul_ctrl
  import shamul_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

  seq_t             state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             done_q;

  assign busy_o = (state_q == SEQ_RUN);
  assign load_o = start_i && !busy_o;
  assign step_o = busy_o;
  assign done_o = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (load_o) begin
        state_q <= SEQ_RUN;
        cnt_q   <= '0;
      end else if (busy_o) begin
        if (cnt_q == LAST) begin
          state_q <= SEQ_IDLE;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  AST_START_TO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(busy_o)); // R3
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R3
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o); // R3
endmodule

// File: rtl/shamul_datapath.sv
`timescale 1ns/1ps
module shamul_datapath #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_i,
  input  logic               step_i,
  input  logic               busy_i,
  input  logic               smode_i,
  input  logic               neg_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic [2*WIDTH-1:0] product_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] acc_q, mpl_q, mcd_q;
  logic             smode_q, neg_q;
  logic [WIDTH-1:0] addend;
  logic [WIDTH:0]   sum;

  // Partial product row: the multiplicand gated by the tested multiplier bit.
  genvar i;
  generate
    for (i = 0; i < WIDTH; i++) begin : g_gate
      assign addend[i] = mcd_q[i] & mpl_q[0];
    end
  endgenerate

  // The adder's carry becomes the new top bit of the accumulator on the shift.
  assign sum = {1'b0, acc_q} + {1'b0, addend};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      mpl_q   <= '0;
      mcd_q   <= '0;
      smode_q <= 1'b0;
      neg_q   <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      mpl_q   <= mplier_i;
      mcd_q   <= mcand_i;
      smode_q <= smode_i;
      neg_q   <= neg_i;
    end else if (step_i) begin
      acc_q <= sum[WIDTH:1];
      mpl_q <= {sum[0], mpl_q[WIDTH-1:1]};
    end
  end

  always_comb begin
    product_o = {acc_q, mpl_q};
    if (smode_q) product_o[PW-1] = neg_q;
  end

  AST_ACC_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (acc_q == '0)); // R4
  AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |=> $stable(mcd_q)); // R7
  AST_PRODUCT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_i && !load_i) |=> $stable(product_o)); // R8
endmodule

// File: rtl/shift_add_mult.sv
`timescale 1ns/1ps
module shift_add_mult #(
  parameter int WIDTH = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic               signed_i,
  input  logic [WIDTH-1:0]   mcand_i,
  input  logic [WIDTH-1:0]   mplier_i,
  output logic               busy_o,
  output logic               done_o,
  output logic [2*WIDTH-1:0] product_o
);
  logic             load, step, neg;
  logic [WIDTH-1:0] mcand_mag, mplier_mag;

  shamul_operand_prep #(.WIDTH(WIDTH)) u_prep (
    .signed_i     (signed_i),
    .mcand_i      (mcand_i),
    .mplier_i     (mplier_i),
    .mcand_mag_o  (mcand_mag),
    .mplier_mag_o (mplier_mag),
    .neg_o        (neg)
  );

  shamul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  shamul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (load),
    .step_i    (step),
    .busy_i    (busy_o),
    .smode_i   (signed_i),
    .neg_i     (neg),
    .mcand_i   (mcand_mag),
    .mplier_i  (mplier_mag),
    .product_o (product_o)
  );

  AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && start_i) |=> (busy_o && !done_o)); // R9
endmodule

// File: tb/sim_shift_add_mult.sv
`timescale 1ns/1ps
module sim_shift_add_mult;
  localparam int W  = 8;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          smode = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          busy, done;
  logic [PW-1:0] prod;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  shift_add_mult #(.WIDTH(W)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start), .signed_i(smode),
    .mcand_i(a), .mplier_i(b), .busy_o(busy), .done_o(done), .product_o(prod)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [PW-1:0] model(input logic [W-1:0] x, input logic [W-1:0] y, input bit sm);
    logic [PW-1:0] r;
    if (!sm) begin
      r = PW'(x) * PW'(y);
    end else begin
      r = PW'(x[W-2:0]) * PW'(y[W-2:0]);
      r[PW-1] = x[W-1] ^ y[W-1];
    end
    return r;
  endfunction

  // Drives start at the current negedge and returns at the done negedge.
  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y, input bit sm, input bit noisy);
    logic [PW-1:0] exp = model(x, y, sm);
    start = 1'b1; a = x; b = y; smode = sm;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < W; i++) begin
      chk(busy === 1'b1, "R2 busy during run", 64'(busy), 64'd1);
      chk(done === 1'b0, "R3 no done during run", 64'(done), 64'd0);
      if (noisy) begin  // R7 disturbances while busy
        start = 1'b1; a = ~x ^ W'(i); b = y + W'(i + 1); smode = ~sm;
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R3 done pulse", {62'd0, busy, done}, 64'd1);
    if (sm)         chk(prod === exp, "R6 signed product", 64'(prod), 64'(exp));
    else if (noisy) chk(prod === exp, "R7 product ignores busy start", 64'(prod), 64'(exp));
    else if (x == '1 && y == '1) chk(prod === exp, "R5 all-ones product", 64'(prod), 64'(exp));
    else            chk(prod === exp, "R4 unsigned product", 64'(prod), 64'(exp));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [PW-1:0] held;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset control", {62'd0, busy, done}, 64'd0);
    chk(prod === '0, "R1 reset product", 64'(prod), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Unsigned sweep, back to back (R9): every start issued in the done cycle.
    for (int x = 0; x < 256; x++) begin
      for (int j = 0; j < 48; j++) begin
        int y = (j < 8) ? j : (j >= 40) ? 208 + j : j * 6;
        run_op(W'(x), W'(y), 1'b0, (x % 17) == 0 && j == 20);
      end
    end
    // R9: the next start was accepted in a done cycle; confirm busy follows
    start = 1'b1; a = 8'd3; b = 8'd5; smode = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1 && done === 1'b0, "R9 start in done cycle accepted", {62'd0, busy, done}, 64'd2);
    repeat (W) @(negedge clk);
    chk(prod === 16'd15, "R9 back-to-back product", 64'(prod), 64'd15);

    // Sign-magnitude sweep, including negative zero and extreme magnitudes.
    for (int x = 0; x < 256; x++) begin
      for (int j = 0; j < 16; j++) begin
        int y = (j * 17) ^ ((j == 8) ? 8 : 0);
        run_op(W'(x), W'(y), 1'b1, (x % 31) == 5 && j == 3);
      end
    end

    // Explicit zero and all-ones boundaries.
    run_op(8'hFF, 8'hFF, 1'b0, 1'b0);  // R5
    run_op(8'h00, 8'hFF, 1'b0, 1'b0);  // R4
    run_op(8'hFF, 8'hFF, 1'b1, 1'b0);  // R6: -127 * -127

    // R8: product holds while idle with inputs moving.
    held = prod;
    for (int k = 0; k < 4; k++) begin
      a = W'(k * 37); b = W'(k * 91); smode = k[0];
      @(negedge clk);
      chk(busy === 1'b0 && done === 1'b0, "R8 idle after done", {62'd0, busy, done}, 64'd0);
      chk(prod === held, "R8 product held", 64'(prod), 64'(held));
    end

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule